// File: doc/BRIEF.md
# Prime-Pair Current-Steering Switch Decoder

This block turns a 6-bit digital code D into the switch controls of a two-source current-steering converter. The converter's resistor ladder has 23 tap nodes. Tap 0 carries weight 0, and taps 1 to 22 carry the primes 2, 3, 5, ... 79 in ascending order. Each of the two current sources is steered into exactly one tap. The decoder picks the two taps so that their weights add up to twice the code. The analog output is therefore proportional to D, because every even number in the range splits into two primes (or into a prime and zero).

Several prime pairs can exist for one code, for example 18 = 5+13 = 7+11. The decoder fixes one pair per code. Array A takes the smallest prime that has a valid partner in the table, and array B takes that partner. The pair table is computed when the design is elaborated and then read as a lookup indexed by the code. Its one-hot outputs are registered.

A two-state controller sets the output-valid flag:
- **ST_IDLE**: no selection is driven.
- **ST_DRIVE**: a selection is driven.
- **Transitions**: ST_IDLE to ST_DRIVE when a valid code arrives; ST_DRIVE stays in ST_DRIVE while valid codes continue; ST_DRIVE returns to ST_IDLE on the first cycle without a valid code.

Top module: `prime_pair_dac_decoder`

## Requirements
- R1: `out_valid` is high in the cycle after each clock edge at which `in_valid` was high, and low in the cycle after each edge at which it was low. Back-to-back codes are accepted every cycle.
- R2: Whenever `out_valid` is high, `sel_a` has exactly one bit set.
- R3: Whenever `out_valid` is high, `sel_b` has exactly one bit set.
- R4: Bit i of each vector selects tap i. Tap 0 weighs 0, and tap i (for i from 1 to 22) weighs the i-th prime in ascending order, starting at 2. For every code D from 0 to 63, weight(`sel_a`) + weight(`sel_b`) = 2·D.
- R5: For codes 1 to 63, `sel_a` holds the smallest prime p for which 2·D − p is a tap weight, and `sel_b` holds 2·D − p. Examples: code 6 gives 5 and 7, code 8 gives 3 and 13, code 9 gives 5 and 13, code 63 gives 47 and 79.
- R6: Code 0 selects tap 0 on both arrays. Code 1 selects tap 1 (weight 2) on A and tap 0 on B. Code 2 selects tap 1 on both arrays.
- R7: In the cycle after an edge at which `in_valid` was low, both `sel_a` and `sel_b` are all zero.
- R8: While `rst_n` is low, and after its release until the first valid code, `out_valid`, `sel_a` and `sel_b` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Code on `code` is to be decoded this cycle |
| code | input | 6 | Converter input code, 0 to 63 |
| out_valid | output | 1 | Switch vectors carry a selection |
| sel_a | output | 23 | One-hot tap select for current source A |
| sel_b | output | 23 | One-hot tap select for current source B |

## Verification
The bench builds the block with its default parameters: a 6-bit code and 23 taps per array. At that size the whole code space of 64 values can be swept exhaustively. This includes the extremes where the pair uses the zero tap (codes 0 and 1) and where it reaches the largest prime (code 63). The bench derives its own prime table and pair rule. It checks every code for both the sum and the smallest-first choice, and it checks a gap in `in_valid` that must clear both arrays.

// File: rtl/pp_dac_pkg.sv
package pp_dac_pkg;

    localparam int MAX_SLOTS = 64;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRIVE = 1'b1
    } drv_state_e;

    // Returns idx_a*256 + idx_b for the chosen tap pair of a code.
    // Tap 0 weighs zero, taps 1.. carry ascending primes.
    function automatic int pair_for_code(input int code_val, input int nslots);
        int w [MAX_SLOTS];
        int cnt;
        int n;
        int res;
        bit found;
        bit isp;
        w[0] = 0;
        for (int k = 1; k < MAX_SLOTS; k++) w[k] = 0;
        cnt = 1;
        n = 2;
        while (cnt < nslots) begin
            isp = 1'b1;
            for (int d = 2; d * d <= n; d++)
                if (n % d == 0) isp = 1'b0;
            if (isp) begin
                w[cnt] = n;
                cnt++;
            end
            n++;
        end
        res = 0;
        found = 1'b0;
        for (int ia = 1; ia < nslots; ia++)
            for (int ib = 0; ib < nslots; ib++)
                if (!found && (w[ia] + w[ib] == 2 * code_val)) begin
                    res = ia * 256 + ib;
                    found = 1'b1;
                end
        return res;
    endfunction

endpackage

// File: rtl/pair_lookup.sv
module pair_lookup #(
    parameter int CODE_W    = 6,
    parameter int NUM_SLOTS = 23,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic [CODE_W-1:0] code,
    output logic [IDX_W-1:0]  idx_a,
    output logic [IDX_W-1:0]  idx_b
);
    localparam int NUM_CODES = 2 ** CODE_W;

    logic [IDX_W-1:0] tbl_a [NUM_CODES];
    logic [IDX_W-1:0] tbl_b [NUM_CODES];

    // One table row per code, built at elaboration.
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_row
        localparam int PAIR = pp_dac_pkg::pair_for_code(c, NUM_SLOTS);
        assign tbl_a[c] = IDX_W'(PAIR / 256);
        assign tbl_b[c] = IDX_W'(PAIR % 256);
    end

    assign idx_a = tbl_a[code];
    assign idx_b = tbl_b[code];
endmodule

// File: rtl/slot_onehot.sv
module slot_onehot #(
    parameter int NUM_SLOTS = 23,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_SLOTS-1:0] onehot
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bit
        assign onehot[i] = (idx == IDX_W'(i));
    end
endmodule

// File: rtl/prime_pair_dac_decoder.sv
module prime_pair_dac_decoder #(
    parameter int CODE_W    = 6,
    parameter int NUM_SLOTS = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [CODE_W-1:0]    code,
    output logic                 out_valid,
    output logic [NUM_SLOTS-1:0] sel_a,
    output logic [NUM_SLOTS-1:0] sel_b
);
    import pp_dac_pkg::*;

    localparam int IDX_W = $clog2(NUM_SLOTS);

    logic [IDX_W-1:0]     idx_a, idx_b;
    logic [NUM_SLOTS-1:0] hot_a, hot_b;
    drv_state_e           state_q, state_d;

    pair_lookup #(.CODE_W(CODE_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_lookup (
        .code  (code),
        .idx_a (idx_a),
        .idx_b (idx_b)
    );

    slot_onehot #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_hot_a (
        .idx    (idx_a),
        .onehot (hot_a)
    );

    slot_onehot #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_hot_b (
        .idx    (idx_b),
        .onehot (hot_b)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid)  state_d = ST_DRIVE;
            ST_DRIVE: if (!in_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Registered switch outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_a <= '0;
            sel_b <= '0;
        end else if (in_valid) begin
            sel_a <= hot_a;
            sel_b <= hot_b;
        end else begin
            sel_a <= '0;
            sel_b <= '0;
        end
    end

    assign out_valid = (state_q == ST_DRIVE);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_a_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot(sel_a));
    assert_b_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot(sel_b));
    assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (sel_a == '0 && sel_b == '0));
    assert_held_code_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $past(in_valid) && $stable(code) && out_valid) |=> $stable(sel_a));
endmodule

// File: tb/tb_prime_pair_dac_decoder.sv
`timescale 1ns/1ps
module tb_prime_pair_dac_decoder;
    localparam int CODE_W = 6;
    localparam int NSL    = 23;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic            out_valid;
    logic [NSL-1:0]  sel_a, sel_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int wt [NSL];

    // code, expected weight A, expected weight B
    localparam int NVEC = 8;
    localparam int VEC [NVEC][3] = '{
        '{0, 0, 0}, '{1, 2, 0}, '{2, 2, 2}, '{3, 3, 3},
        '{6, 5, 7}, '{8, 3, 13}, '{9, 5, 13}, '{63, 47, 79}
    };

    always #2 clk = ~clk;

    prime_pair_dac_decoder #(.CODE_W(CODE_W), .NUM_SLOTS(NSL)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .code(code),
        .out_valid(out_valid), .sel_a(sel_a), .sel_b(sel_b)
    );

    function automatic int hot_index(input logic [NSL-1:0] v);
        int idx = -1;
        if ($countones(v) != 1) return -1;
        for (int i = 0; i < NSL; i++) if (v[i]) idx = i;
        return idx;
    endfunction

    function automatic bit in_table(input int w);
        for (int i = 0; i < NSL; i++) if (wt[i] == w) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int expect_a(input int d);
        if (d == 0) return 0;
        for (int i = 1; i < NSL; i++) if (in_table(2 * d - wt[i])) return wt[i];
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int c);
        in_valid = v;
        code = CODE_W'(c);
        @(negedge clk);
    endtask

    task automatic check_code(input int d);
        int ia, ib, wa, wb;
        ia = hot_index(sel_a);
        ib = hot_index(sel_b);
        check(out_valid == 1'b1, "R1", int'(out_valid), 1);
        check(ia >= 0, "R2", $countones(sel_a), 1);
        check(ib >= 0, "R3", $countones(sel_b), 1);
        wa = (ia >= 0) ? wt[ia] : -1;
        wb = (ib >= 0) ? wt[ib] : -1;
        check(wa + wb == 2 * d, "R4", wa + wb, 2 * d);
        check(wa == expect_a(d), "R5", wa, expect_a(d));
    endtask

    initial begin
        int cnt, n;
        bit isp;
        wt[0] = 0;
        cnt = 1;
        n = 2;
        while (cnt < NSL) begin
            isp = 1'b1;
            for (int d = 2; d * d <= n; d++) if (n % d == 0) isp = 1'b0;
            if (isp) begin wt[cnt] = n; cnt++; end
            n++;
        end

        @(negedge clk);
        @(negedge clk);
        // R8 reset state
        check(out_valid == 1'b0, "R8", int'(out_valid), 0);
        check(sel_a == '0 && sel_b == '0, "R8", $countones(sel_a | sel_b), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && sel_a == '0, "R8", int'(out_valid), 0);

        // Directed vector table
        for (int k = 0; k < NVEC; k++) begin
            drive(1'b1, VEC[k][0]);
            check_code(VEC[k][0]);
            check(hot_index(sel_a) >= 0 && wt[hot_index(sel_a)] == VEC[k][1], "R5",
                  hot_index(sel_a), VEC[k][1]);
            check(hot_index(sel_b) >= 0 && wt[hot_index(sel_b)] == VEC[k][2], "R5",
                  hot_index(sel_b), VEC[k][2]);
        end

        // R6 zero-tap corners by index
        drive(1'b1, 0);
        check(sel_a == NSL'(1) && sel_b == NSL'(1), "R6", hot_index(sel_a), 0);
        drive(1'b1, 1);
        check(sel_a == NSL'(2) && sel_b == NSL'(1), "R6", hot_index(sel_a), 1);
        drive(1'b1, 2);
        check(sel_a == NSL'(2) && sel_b == NSL'(2), "R6", hot_index(sel_b), 1);

        // Back-to-back sweep of all codes, ascending then descending (R1, R4)
        for (int d = 0; d < 64; d++) begin
            drive(1'b1, d);
            check_code(d);
        end
        for (int d = 63; d >= 0; d--) begin
            drive(1'b1, d);
            check_code(d);
        end

        // R7 gap in valid clears both arrays, code still changing
        drive(1'b0, 63);
        check(out_valid == 1'b0, "R7", int'(out_valid), 0);
        check(sel_a == '0 && sel_b == '0, "R7", $countones(sel_a | sel_b), 0);
        drive(1'b0, 9);
        check(sel_a == '0 && sel_b == '0, "R7", $countones(sel_a | sel_b), 0);
        drive(1'b1, 9);
        check_code(9);

        // Reset in mid-stream (R8)
        rst_n = 1'b0;
        drive(1'b1, 40);
        check(out_valid == 1'b0 && sel_a == '0 && sel_b == '0, "R8", int'(out_valid), 0);
        rst_n = 1'b1;
        drive(1'b1, 40);
        check_code(40);
        drive(1'b0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule